// File: doc/BRIEF.md
# Set-Associative Data Cache with Scratchpad Bypass

This block is a per-core data store that holds two kinds of data in one array. Each request carries a space flag. Scratchpad requests go straight to a reserved region of the data array, with no tag check, and may read or write a single 32-bit word. Global requests are reads. They pass through a 4-way, 16-set tag stage that holds 8-word lines. A hit is answered one cycle after the request is accepted.

On a global miss, the block raises a line request on its miss port and holds it there. The lower memory level answers with one full line on the fill port. In the cycle the fill arrives, the line is written into the victim way of its set and the requested word is passed to the requester. Only one miss can be open at a time. While it is open, the block refuses every new request of either space.

The victim is an invalid way if the set has one, taking the lowest numbered. Otherwise it is the way chosen by a 3-bit tree pseudo-LRU kept for each set. Addresses are word addresses.

Top module: `l1_bypass_cache`

## Requirements
- R1: A scratchpad read (reqSpace=1, reqWrite=0) is answered with respValid=1 exactly one cycle after acceptance. It returns the word last written to the same scratchpad word address, taken from reqAddr[7:0], and it never raises missValid.
- R2: A scratchpad write (reqSpace=1, reqWrite=1) stores reqWdata and produces no response in the following cycle.
- R3: A global address splits into word offset reqAddr[2:0], set reqAddr[6:3] and tag reqAddr[29:7]. A global read whose line is not resident raises missValid one cycle after acceptance, with missAddr = reqAddr[29:3]. missAddr holds stable until the fill arrives.
- R4: In the cycle that fillValid is high while a miss is open, respValid is 1 and respData is the requested word of fillData. Word w occupies bits [32w+31:32w].
- R5: While a miss is open, reqReady is 0 for requests of both spaces. reqReady returns to 1 and missValid drops in the cycle after the fill.
- R6: A global read of a resident line returns its word one cycle after acceptance, without raising missValid.
- R7: Four distinct tags mapping to one set are all resident after their fills, because invalid ways are filled before any valid way is replaced.
- R8: When a set is full, a miss replaces the way selected by the tree pseudo-LRU. Every hit and every fill points the tree away from the way just used.
- R9: Synchronous reset leaves reqReady=1, respValid=0 and missValid=0, and invalidates every line, so a previously cached line misses again.
- R10: reqWrite has no effect on a global request: the request behaves as a read, and the cached line keeps the fill data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqSpace | input | 1 | 1 = scratchpad, 0 = global |
| reqWrite | input | 1 | Write flag, honoured for scratchpad only |
| reqAddr | input | 30 | Word address |
| reqWdata | input | 32 | Write data for scratchpad writes |
| respValid | output | 1 | Response word valid |
| respData | output | 32 | Response word |
| missValid | output | 1 | Line request to the lower level is open |
| missAddr | output | 27 | Line address of the open miss |
| fillValid | input | 1 | Fill line present |
| fillData | input | 256 | Fill line, word w at bits [32w+31:32w] |

## Verification
The bench fills one set with four tags. It then touches a chosen way and forces a fifth tag, so the pseudo-LRU victim is known ahead of time. A design that updated the tree in the wrong direction, or that ignored free ways, would evict a different line, and the follow-up hit/miss probes would expose it. While a miss is open, the bench offers a scratchpad read and expects it refused. A design that let the scratchpad through during a miss would respond out of turn. A global request with the write flag set must still miss and return memory data. A design that treated it as a write would return the write data on the next hit. A reset after caching must make the same line miss again; a design with stale valid bits would return a hit.

// File: rtl/l1b_pkg.sv
package l1b_pkg;
  localparam int ADDR_W     = 30;
  localparam int WORD_W     = 32;
  localparam int WAYS       = 4;
  localparam int LINE_WORDS = 8;
  localparam int SETS       = 16;
  localparam int SP_LINES   = 32;
  localparam int OFF_W      = $clog2(LINE_WORDS);
  localparam int SET_W      = $clog2(SETS);
  localparam int WAY_W      = $clog2(WAYS);
  localparam int TAG_W      = ADDR_W - SET_W - OFF_W;
  localparam int LINE_W     = LINE_WORDS * WORD_W;
  localparam int LADDR_W    = ADDR_W - OFF_W;

  typedef struct packed {
    logic lookup;
    logic spRead;
    logic spWrite;
    logic fill;
  } strobe_t;
endpackage

// File: rtl/l1b_ctrl.sv
module l1b_ctrl
  import l1b_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqSpace,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              hit,
  input  logic              fillValid,
  output logic              reqReady,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] pendAddr,
  output logic              missValid,
  output logic [LADDR_W-1:0] missAddr,
  output logic              respValid
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_t;

  state_t state;
  logic   respReg;
  logic   accept;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    stb.lookup  = accept && !reqSpace;
    stb.spRead  = accept && reqSpace && !reqWrite;
    stb.spWrite = accept && reqSpace && reqWrite;
    stb.fill    = (state == ST_WAIT) && fillValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      respReg  <= 1'b0;
      pendAddr <= '0;
    end else begin
      respReg <= stb.spRead || (stb.lookup && hit);
      if (stb.lookup && !hit) begin
        state    <= ST_WAIT;
        pendAddr <= reqAddr;
      end else if (stb.fill) begin
        state <= ST_IDLE;
      end
    end
  end

  assign missValid = (state == ST_WAIT);
  assign missAddr  = pendAddr[ADDR_W-1:OFF_W];
  assign respValid = respReg || stb.fill;
endmodule

// File: rtl/l1b_dpath.sv
module l1b_dpath
  import l1b_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic [ADDR_W-1:0] pendAddr,
  input  logic [LINE_W-1:0] fillData,
  output logic              hit,
  output logic [WORD_W-1:0] respData
);
  localparam int CACHE_LINES = SETS * WAYS;
  localparam int DEPTH       = CACHE_LINES + SP_LINES;
  localparam int IDX_W       = $clog2(DEPTH);
  localparam int SP_W        = $clog2(SP_LINES);

  logic [TAG_W-1:0]  tagArr   [SETS][WAYS];
  logic [WAYS-1:0]   validArr [SETS];
  logic [WAYS-2:0]   plruArr  [SETS];
  logic [LINE_W-1:0] dataArr  [DEPTH];

  logic [OFF_W-1:0] reqOff, pendOff, rdOff;
  logic [SET_W-1:0] reqSet, pendSet;
  logic [TAG_W-1:0] reqTag, pendTag;
  logic [SP_W-1:0]  spLine;
  logic [WAYS-1:0]  wayMatch;
  logic [WAY_W-1:0] hitWay, victim;
  logic [IDX_W-1:0] spIdx, rdIdx, fillIdx;
  logic [LINE_W-1:0] rdLine;

  assign reqOff  = reqAddr[OFF_W-1:0];
  assign reqSet  = reqAddr[OFF_W +: SET_W];
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign pendOff = pendAddr[OFF_W-1:0];
  assign pendSet = pendAddr[OFF_W +: SET_W];
  assign pendTag = pendAddr[ADDR_W-1 -: TAG_W];
  assign spLine  = reqAddr[OFF_W +: SP_W];

  function automatic logic [WAYS-2:0] plruTouch(input logic [WAYS-2:0] cur,
                                                 input logic [WAY_W-1:0] way);
    logic [WAYS-2:0] nxt;
    nxt = cur;
    if (!way[1]) begin
      nxt[0] = 1'b1;
      nxt[1] = !way[0];
    end else begin
      nxt[0] = 1'b0;
      nxt[2] = !way[0];
    end
    return nxt;
  endfunction

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayMatch[w] = validArr[reqSet][w] && (tagArr[reqSet][w] == reqTag);
  end
  assign hit = |wayMatch;

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (wayMatch[w]) hitWay = WAY_W'(w);
  end

  always_comb begin
    logic freeFound;
    logic [WAYS-2:0] p;
    freeFound = 1'b0;
    victim    = '0;
    p         = plruArr[pendSet];
    for (int w = WAYS - 1; w >= 0; w--)
      if (!validArr[pendSet][w]) begin
        victim    = WAY_W'(w);
        freeFound = 1'b1;
      end
    if (!freeFound)
      victim = p[0] ? (p[2] ? 2'd3 : 2'd2) : (p[1] ? 2'd1 : 2'd0);
  end

  assign spIdx   = IDX_W'(CACHE_LINES) + IDX_W'(spLine);
  assign rdIdx   = stb.spRead ? spIdx : IDX_W'({reqSet, hitWay});
  assign fillIdx = IDX_W'({pendSet, victim});

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        plruArr[s]  <= '0;
      end
    end else begin
      if (stb.fill) begin
        validArr[pendSet][victim] <= 1'b1;
        tagArr[pendSet][victim]   <= pendTag;
        plruArr[pendSet]          <= plruTouch(plruArr[pendSet], victim);
      end
      if (stb.lookup && hit)
        plruArr[reqSet] <= plruTouch(plruArr[reqSet], hitWay);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.fill)
      dataArr[fillIdx] <= fillData;
    if (stb.spWrite)
      dataArr[spIdx][reqOff*WORD_W +: WORD_W] <= reqWdata;
    if (stb.lookup || stb.spRead) begin
      rdLine <= dataArr[rdIdx];
      rdOff  <= reqOff;
    end
  end

  assign respData = stb.fill ? fillData[pendOff*WORD_W +: WORD_W]
                             : rdLine[rdOff*WORD_W +: WORD_W];
endmodule

// File: rtl/l1_bypass_cache.sv
module l1_bypass_cache
  import l1b_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqSpace,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [WORD_W-1:0]  reqWdata,
  output logic               respValid,
  output logic [WORD_W-1:0]  respData,
  output logic               missValid,
  output logic [LADDR_W-1:0] missAddr,
  input  logic               fillValid,
  input  logic [LINE_W-1:0]  fillData
);
  strobe_t           stb;
  logic              hit;
  logic [ADDR_W-1:0] pendAddr;

  l1b_ctrl ctrl_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqSpace(reqSpace),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .hit(hit), .fillValid(fillValid),
    .reqReady(reqReady), .stb(stb), .pendAddr(pendAddr), .missValid(missValid),
    .missAddr(missAddr), .respValid(respValid)
  );

  l1b_dpath dpath_i (
    .clk(clk), .rst(rst), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .pendAddr(pendAddr), .fillData(fillData), .hit(hit), .respData(respData)
  );
endmodule

// File: rtl/l1b_chk.sv
module l1b_chk
  import l1b_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               reqValid,
  input logic               reqReady,
  input logic               reqSpace,
  input logic               reqWrite,
  input logic               respValid,
  input logic               missValid,
  input logic [LADDR_W-1:0] missAddr,
  input logic               fillValid
);
  // R5
  stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
    missValid |-> !reqReady);

  // R3
  miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (missValid && !fillValid) |=> (missValid && $stable(missAddr)));

  // R4
  fill_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (missValid && fillValid) |-> respValid);

  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (missValid && fillValid) |=> (reqReady && !missValid));

  // R1
  sp_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && reqSpace && !reqWrite) |=> (respValid && !missValid));

  // R2
  sp_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && reqSpace && reqWrite) |=> !respValid);
endmodule

bind l1_bypass_cache l1b_chk chk_i (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
  .reqSpace(reqSpace), .reqWrite(reqWrite), .respValid(respValid),
  .missValid(missValid), .missAddr(missAddr), .fillValid(fillValid)
);

// File: tb/l1_bypass_cache_tb.sv
module l1_bypass_cache_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reqValid = 1'b0, reqSpace = 1'b0, reqWrite = 1'b0;
  logic [29:0]  reqAddr = '0;
  logic [31:0]  reqWdata = '0;
  logic         reqReady, respValid, missValid;
  logic [31:0]  respData;
  logic [26:0]  missAddr;
  logic         fillValid = 1'b0;
  logic [255:0] fillData = '0;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  l1_bypass_cache dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqSpace(reqSpace), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .respValid(respValid), .respData(respData),
    .missValid(missValid), .missAddr(missAddr), .fillValid(fillValid),
    .fillData(fillData)
  );

  typedef struct packed {
    logic        sp;
    logic        wr;
    logic [29:0] a;
    logic [31:0] d;
    logic        miss;
    logic        fromMem;
    logic [31:0] e;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 30'h004, 32'hDEADBEEF, 1'b0, 1'b0, 32'h0, 8'd2},        // R2 sp write
    '{1'b1, 1'b1, 30'h0FF, 32'h01234567, 1'b0, 1'b0, 32'h0, 8'd2},        // R2 last sp word
    '{1'b1, 1'b0, 30'h004, 32'h0,        1'b0, 1'b0, 32'hDEADBEEF, 8'd1}, // R1
    '{1'b1, 1'b0, 30'h0FF, 32'h0,        1'b0, 1'b0, 32'h01234567, 8'd1}, // R1
    '{1'b0, 1'b0, 30'h400, 32'h0,        1'b1, 1'b1, 32'h0, 8'd4},        // R4 miss set0
    '{1'b0, 1'b0, 30'h407, 32'h0,        1'b0, 1'b1, 32'h0, 8'd6},        // R6 hit word7
    '{1'b0, 1'b0, 30'h809, 32'h0,        1'b1, 1'b1, 32'h0, 8'd4},        // R4 miss set1
    '{1'b0, 1'b0, 30'h402, 32'h0,        1'b0, 1'b1, 32'h0, 8'd6},        // R6 hit set0
    '{1'b1, 1'b0, 30'h004, 32'h0,        1'b0, 1'b0, 32'hDEADBEEF, 8'd1}, // R1 unaffected by fills
    '{1'b0, 1'b1, 30'hC12, 32'hBADBAD00, 1'b1, 1'b1, 32'h0, 8'd10},       // R10 write flag ignored
    '{1'b0, 1'b0, 30'hC12, 32'h0,        1'b0, 1'b1, 32'h0, 8'd10}        // R10 line kept fill data
  };

  function automatic logic [31:0] memWord(input logic [29:0] a);
    return ({2'b00, a} * 32'h0001_0003) ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [255:0] lineOf(input logic [29:0] a);
    logic [255:0] l;
    for (int w = 0; w < 8; w++) l[32*w +: 32] = memWord({a[29:3], 3'(w)});
    return l;
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic access(input bit sp, input bit wr, input logic [29:0] a,
                        input logic [31:0] wd, input bit expMiss,
                        input logic [31:0] expD, input string rq);
    @(negedge clk);
    reqValid = 1'b1; reqSpace = sp; reqWrite = wr; reqAddr = a; reqWdata = wd;
    #1 check(reqReady, "R5", 32'(reqReady), 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    if (sp && wr) begin
      check(!respValid, "R2", 32'(respValid), 32'd0);
      check(!missValid, "R2", 32'(missValid), 32'd0);
    end else if (!expMiss) begin
      check(respValid && respData == expD, rq, respData, expD);
      check(!missValid, rq, 32'(missValid), 32'd0);
    end else begin
      check(missValid, "R3", 32'(missValid), 32'd1);
      check(missAddr == a[29:3], "R3", 32'(missAddr), 32'(a[29:3]));
      check(!respValid, "R3", 32'(respValid), 32'd0);
      reqValid = 1'b1; reqSpace = 1'b1; reqWrite = 1'b0; reqAddr = 30'h004;
      #1 check(!reqReady, "R5", 32'(reqReady), 32'd0);
      @(negedge clk);
      reqValid = 1'b0;
      #1 check(missValid && missAddr == a[29:3], "R3", 32'(missAddr), 32'(a[29:3]));
      check(!respValid, "R5", 32'(respValid), 32'd0);
      fillValid = 1'b1; fillData = lineOf(a);
      #1 check(respValid && respData == expD, "R4", respData, expD);
      @(negedge clk);
      fillValid = 1'b0;
      #1 check(reqReady && !missValid && !respValid, "R5",
               {29'd0, reqReady, missValid, respValid}, 32'h4);
    end
  endtask

  function automatic logic [29:0] pa(input logic [22:0] tag);
    return {tag, 4'd5, 3'd3};
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    check(reqReady && !respValid && !missValid, "R9",
          {29'd0, reqReady, respValid, missValid}, 32'h4);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v = VECS[i];
      access(v.sp, v.wr, v.a, v.d, v.miss, v.fromMem ? memWord(v.a) : v.e,
             $sformatf("R%0d", v.req));
    end

    // R7: four tags in set 5 all resident
    for (int t = 0; t < 4; t++) access(0, 0, pa(23'h20 + 23'(t)), 0, 1, memWord(pa(23'h20 + 23'(t))), "R7");
    for (int t = 0; t < 4; t++) access(0, 0, pa(23'h20 + 23'(t)), 0, 0, memWord(pa(23'h20 + 23'(t))), "R7");

    // R8: touch way of tag 0x20, then fifth tag evicts tag 0x22
    access(0, 0, pa(23'h20), 0, 0, memWord(pa(23'h20)), "R8");
    access(0, 0, pa(23'h24), 0, 1, memWord(pa(23'h24)), "R8");
    access(0, 0, pa(23'h20), 0, 0, memWord(pa(23'h20)), "R8");
    access(0, 0, pa(23'h21), 0, 0, memWord(pa(23'h21)), "R8");
    access(0, 0, pa(23'h23), 0, 0, memWord(pa(23'h23)), "R8");
    access(0, 0, pa(23'h24), 0, 0, memWord(pa(23'h24)), "R8");
    access(0, 0, pa(23'h22), 0, 1, memWord(pa(23'h22)), "R8");

    // R9: reset invalidates cached lines
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    #1 check(reqReady && !missValid, "R9", {30'd0, reqReady, missValid}, 32'h2);
    access(0, 0, 30'h407, 0, 1, memWord(30'h407), "R9");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule